// File: doc/BRIEF.md
# Cycle-Slip Loss-of-Lock Detector

This block watches a fast oscillator clock against a slower word-rate reference and reports when the two have lost frequency lock. The fast clock drives a divide-by-16 counter, and the wrap of that counter is the divided-clock edge. Falling edges of the reference are brought into the fast-clock domain and compared in order with the divided-clock edges. In a locked loop the two kinds of event alternate. Whenever one side produces two events in a row with none from the other side in between, a whole reference cycle has been gained or lost. That is a cycle slip, and it produces a one-cycle raw pulse together with a pulse that gives its direction.

A raw slip pulse is too short to be used directly. An internal stretcher turns it into an active-low lock indicator: the output stays low for a programmable number of slip-free reference cycles after the most recent slip. After reset the indicator stays low until 16 consecutive slip-free reference cycles have been seen. A typical setting for the stretch length is 1024.

The slip state machine has three states. SL_START is the state after reset, with no event seen yet. SL_REF_LAST means the most recent unpaired event was a reference edge. SL_DIV_LAST means it was a divided-clock edge. Its transitions are:
- first-ref: SL_START to SL_REF_LAST.
- first-div: SL_START to SL_DIV_LAST.
- pair-ref: SL_DIV_LAST to SL_REF_LAST.
- pair-div: SL_REF_LAST to SL_DIV_LAST.
- slip-up: SL_REF_LAST to itself on a lone reference edge.
- slip-down: SL_DIV_LAST to itself on a lone divided edge.
- coincide: any state to itself when both edges arrive in the same cycle.

The lock state machine also has three states: LK_ACQUIRE after reset, LK_HOLD while stretching, and LK_LOCKED. Its transitions are:
- acquire-done: LK_ACQUIRE to LK_LOCKED on the 16th clean reference edge.
- slip-hit: LK_LOCKED to LK_HOLD on a slip.
- hold-done: LK_HOLD to LK_LOCKED when the stretch count is reached.
- restart: LK_ACQUIRE or LK_HOLD to itself on a slip, which clears the count.

Top module: `lol_slip_detector`

## Requirements
- R1: While rst_n is low, lock_n, slip_raw, slip_up and slip_dn are all 0.
- R2: When reference falling edges come every 16 fast-clock cycles, no slip pulse of either direction is produced.
- R3: Two reference falling edges with no divided-clock edge between them produce exactly one one-cycle slip_up pulse.
- R4: The divided-clock edge occurs once every 16 fast-clock cycles. Two divided-clock edges with no reference falling edge between them produce exactly one one-cycle slip_dn pulse.
- R5: slip_raw is 1 in exactly the cycles where slip_up or slip_dn is 1, and slip_up and slip_dn are never 1 together.
- R6: A slip drives lock_n to 0 in the same cycle as slip_raw. lock_n stays 0 until stretch_len slip-free reference falling edges have been seen, then returns to 1. A stretch_len of 0 behaves as 1.
- R7: A slip that occurs while lock_n is being held low restarts the stretch count from zero.
- R8: After reset, lock_n stays 0 until 16 consecutive slip-free reference falling edges have been seen. A slip during that time restarts the count.
- R9: ref_clk passes through a two-stage synchronizer. Only its high-to-low transitions are reference events, so a held level produces none. lock_n rises only in the cycle after a reference event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Word-rate reference clock, asynchronous to clk_fast |
| stretch_len | input | CNT_W | Number of slip-free reference cycles lock_n is held low after a slip |
| slip_raw | output | 1 | One-cycle pulse per detected cycle slip |
| slip_up | output | 1 | Slip pulse: reference produced an extra edge |
| slip_dn | output | 1 | Slip pulse: divided clock produced an extra edge |
| lock_n | output | 1 | Active-low lock indicator (0 = out of lock) |

## Verification
The bench builds the block with its default parameters: a divide ratio of 16, an acquisition window of 16 and a 12-bit stretch counter. It then drives stretch_len through the port at 0, 5 and 32, so that release and restart of the stretcher fall within a few dozen reference periods. Reference periods of 14, 16 and 18 fast cycles exercise both slip directions and the locked case. A single skipped edge, a single inserted edge and long held levels show single slips, hold restarts and the event-only nature of the reference path.

// File: rtl/lol_pkg.sv
package lol_pkg;

    typedef enum logic [1:0] {
        SL_START    = 2'd0,
        SL_REF_LAST = 2'd1,
        SL_DIV_LAST = 2'd2
    } slip_state_t;

    typedef enum logic [1:0] {
        LK_ACQUIRE = 2'd0,
        LK_HOLD    = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_state_t;

endpackage

// File: rtl/lol_ref_sync.sv
module lol_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_fall
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], ref_in};
        end
    end

    assign ref_fall = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/lol_divider.sv
module lol_divider #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_edge
);
    localparam int W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign div_edge = (cnt == LAST);

endmodule

// File: rtl/lol_slip_fsm.sv
module lol_slip_fsm
    import lol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_fall,
    input  logic div_edge,
    output logic slip_evt,
    output logic slip_raw,
    output logic slip_up,
    output logic slip_dn
);
    slip_state_t state, state_nx;
    logic up_nx, dn_nx;

    always_comb begin
        state_nx = state;
        up_nx    = 1'b0;
        dn_nx    = 1'b0;
        unique case (state)
            SL_START: begin
                if (ref_fall && !div_edge)      state_nx = SL_REF_LAST;
                else if (div_edge && !ref_fall) state_nx = SL_DIV_LAST;
            end
            SL_REF_LAST: begin
                if (ref_fall && !div_edge)      up_nx    = 1'b1;
                else if (div_edge && !ref_fall) state_nx = SL_DIV_LAST;
            end
            SL_DIV_LAST: begin
                if (div_edge && !ref_fall)      dn_nx    = 1'b1;
                else if (ref_fall && !div_edge) state_nx = SL_REF_LAST;
            end
            default: state_nx = SL_START;
        endcase
    end

    assign slip_evt = up_nx | dn_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SL_START;
        else        state <= state_nx;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slip_up  <= 1'b0;
            slip_dn  <= 1'b0;
            slip_raw <= 1'b0;
        end else begin
            slip_up  <= up_nx;
            slip_dn  <= dn_nx;
            slip_raw <= slip_evt;
        end
    end

endmodule

// File: rtl/lol_lock_fsm.sv
module lol_lock_fsm
    import lol_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int ACQ_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_fall,
    input  logic             slip_evt,
    input  logic [CNT_W-1:0] stretch_len,
    output logic             lock_n
);
    localparam logic [CNT_W:0] ACQ_END = (CNT_W+1)'(ACQ_CYCLES);

    lock_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W:0]   cnt_inc;
    logic             clean;
    logic             hold_done;
    logic             acq_done;

    assign clean     = ref_fall & ~slip_evt;
    assign cnt_inc   = {1'b0, cnt} + 1'b1;
    assign hold_done = (cnt_inc >= {1'b0, stretch_len});
    assign acq_done  = (cnt_inc >= ACQ_END);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            LK_ACQUIRE: begin
                if (slip_evt) begin
                    cnt_nx = '0;
                end else if (clean) begin
                    if (acq_done) begin
                        state_nx = LK_LOCKED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            LK_HOLD: begin
                if (slip_evt) begin
                    cnt_nx = '0;
                end else if (clean) begin
                    if (hold_done) begin
                        state_nx = LK_LOCKED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            LK_LOCKED: begin
                if (slip_evt) begin
                    state_nx = LK_HOLD;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = LK_ACQUIRE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_ACQUIRE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_n <= 1'b0;
        else        lock_n <= (state_nx == LK_LOCKED);
    end

endmodule

// File: rtl/lol_slip_detector.sv
module lol_slip_detector #(
    parameter int DIV_RATIO   = 16,
    parameter int ACQ_CYCLES  = 16,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic [CNT_W-1:0] stretch_len,
    output logic             slip_raw,
    output logic             slip_up,
    output logic             slip_dn,
    output logic             lock_n
);
    logic ref_fall;
    logic div_edge;
    logic slip_evt;

    lol_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .ref_in   (ref_clk),
        .ref_fall (ref_fall)
    );

    lol_divider #(.RATIO(DIV_RATIO)) u_div (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .div_edge (div_edge)
    );

    lol_slip_fsm u_slip (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .ref_fall (ref_fall),
        .div_edge (div_edge),
        .slip_evt (slip_evt),
        .slip_raw (slip_raw),
        .slip_up  (slip_up),
        .slip_dn  (slip_dn)
    );

    lol_lock_fsm #(.CNT_W(CNT_W), .ACQ_CYCLES(ACQ_CYCLES)) u_lock (
        .clk         (clk_fast),
        .rst_n       (rst_n),
        .ref_fall    (ref_fall),
        .slip_evt    (slip_evt),
        .stretch_len (stretch_len),
        .lock_n      (lock_n)
    );

endmodule

// File: rtl/lol_slip_checker.sv
module lol_slip_checker (
    input logic clk,
    input logic rst_n,
    input logic lock_n,
    input logic slip_raw,
    input logic slip_up,
    input logic slip_dn,
    input logic ref_fall,
    input logic div_edge
);

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |-> (!lock_n && !slip_raw && !slip_up && !slip_dn));

    a_r3_up_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        slip_up |-> $past(ref_fall));

    a_r4_dn_on_div: assert property (@(posedge clk) disable iff (!rst_n)
        slip_dn |-> $past(div_edge));

    a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(slip_up && slip_dn));

    a_r5_raw_has_dir: assert property (@(posedge clk) disable iff (!rst_n)
        slip_raw |-> (slip_up || slip_dn));

    a_r5_dir_has_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_up || slip_dn) |-> slip_raw);

    a_r6_slip_low: assert property (@(posedge clk) disable iff (!rst_n)
        slip_raw |-> !lock_n);

    a_r9_rise_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |-> $past(ref_fall));

endmodule

bind lol_slip_detector lol_slip_checker u_chk (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .lock_n   (lock_n),
    .slip_raw (slip_raw),
    .slip_up  (slip_up),
    .slip_dn  (slip_dn),
    .ref_fall (ref_fall),
    .div_edge (div_edge)
);

// File: tb/lol_slip_detector_test.sv
`timescale 1ns/1ps
module lol_slip_detector_test;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b1;
    logic [CW-1:0] stretch_len = 12'd32;
    logic          slip_raw, slip_up, slip_dn, lock_n;

    int checks = 0;
    int errors = 0;
    int n_up = 0, n_dn = 0, n_raw = 0;
    int u0, d0, r0;

    always #10 clk = ~clk;

    lol_slip_detector uut (
        .clk_fast    (clk),
        .rst_n       (rst_n),
        .ref_clk     (ref_clk),
        .stretch_len (stretch_len),
        .slip_raw    (slip_raw),
        .slip_up     (slip_up),
        .slip_dn     (slip_dn),
        .lock_n      (lock_n)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (slip_up)  n_up  <= n_up + 1;
            if (slip_dn)  n_dn  <= n_dn + 1;
            if (slip_raw) n_raw <= n_raw + 1;
        end
    end

    // half period, periods, stretch, up code, dn code, lock code
    // codes: 0 = must be zero / low, 1 = must be nonzero / high, 2 = not checked
    localparam int NROW = 6;
    localparam int TBL [NROW][6] = '{
        '{8, 24, 32, 0, 0, 1},
        '{7, 40, 32, 1, 0, 0},
        '{8, 50, 32, 2, 2, 1},
        '{9, 40, 32, 0, 1, 0},
        '{8, 50, 32, 2, 2, 1},
        '{8, 20,  4, 0, 0, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic hold_ref(input logic lvl, input int n);
        ref_clk = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic periods(input int half, input int n);
        for (int k = 0; k < n; k++) begin
            hold_ref(1'b1, half);
            hold_ref(1'b0, half);
        end
    endtask

    task automatic skip_edge();
        hold_ref(1'b1, 24);
        hold_ref(1'b0, 8);
    endtask

    task automatic extra_edge();
        hold_ref(1'b1, 4);
        hold_ref(1'b0, 4);
        hold_ref(1'b1, 4);
        hold_ref(1'b0, 4);
    endtask

    task automatic mark();
        u0 = n_up; d0 = n_dn; r0 = n_raw;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 lock_n in reset", int'(lock_n), 0);
        check("R1 slip_raw in reset", int'(slip_raw), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) begin
            mark();
            stretch_len = CW'(TBL[i][2]);
            periods(TBL[i][0], TBL[i][1]);
            if (TBL[i][3] == 0) check("R2 no up slip", n_up - u0, 0);
            else if (TBL[i][3] == 1) check("R3 up slips seen", int'(n_up > u0), 1);
            if (TBL[i][4] == 0) check("R2 no dn slip", n_dn - d0, 0);
            else if (TBL[i][4] == 1) check("R4 dn slips seen", int'(n_dn > d0), 1);
            check("R5 raw equals up+dn", n_raw - r0, (n_up - u0) + (n_dn - d0));
            if (TBL[i][5] != 2)
                check(i == 0 ? "R8 lock after acquire" : "R6 lock state", int'(lock_n), TBL[i][5]);
        end

        // single missing edge, stretch 5 (R4, R5, R6)
        stretch_len = 12'd5;
        mark();
        skip_edge();
        check("R4 one dn slip", n_dn - d0, 1);
        check("R4 no up slip", n_up - u0, 0);
        check("R5 one raw slip", n_raw - r0, 1);
        check("R6 low after slip", int'(lock_n), 0);
        periods(8, 2);
        check("R6 still low at 3 of 5", int'(lock_n), 0);
        periods(8, 4);
        check("R6 released after 5", int'(lock_n), 1);

        // slip during hold restarts (R7)
        skip_edge();
        periods(8, 2);
        skip_edge();
        periods(8, 2);
        check("R7 hold restarted", int'(lock_n), 0);
        periods(8, 6);
        check("R7 released after restart", int'(lock_n), 1);

        // stretch 0 acts as 1 (R6)
        stretch_len = 12'd0;
        mark();
        skip_edge();
        check("R6 zero stretch slip seen", n_raw - r0, 1);
        check("R6 zero stretch released", int'(lock_n), 1);

        // single inserted edge (R3)
        stretch_len = 12'd5;
        periods(8, 8);
        mark();
        extra_edge();
        periods(8, 1);
        check("R3 one up slip", n_up - u0, 1);
        check("R3 no dn slip", n_dn - d0, 0);
        check("R6 low after up slip", int'(lock_n), 0);
        periods(8, 8);
        check("R6 released after up slip", int'(lock_n), 1);

        // held levels: no reference events (R9), divide by 16 (R4)
        mark();
        hold_ref(1'b0, 400);
        check_range("R4 dn slips per 16 cycles", n_dn - d0, 22, 26);
        check("R9 held low no up", n_up - u0, 0);
        check("R9 held low lock", int'(lock_n), 0);
        mark();
        hold_ref(1'b1, 400);
        check("R9 held high no up", n_up - u0, 0);
        check("R9 held high lock", int'(lock_n), 0);
        periods(8, 12);
        check("R9 lock back after edges", int'(lock_n), 1);

        // reset mid-run (R1) and acquisition (R8)
        rst_n = 1'b0;
        hold_ref(1'b1, 3);
        check("R1 lock_n low in reset", int'(lock_n), 0);
        check("R1 slip_up low in reset", int'(slip_up), 0);
        check("R1 slip_dn low in reset", int'(slip_dn), 0);
        check("R1 slip_raw low in reset", int'(slip_raw), 0);
        rst_n = 1'b1;
        stretch_len = 12'd1;
        periods(8, 14);
        check("R8 low before 16 clean", int'(lock_n), 0);
        periods(8, 4);
        check("R8 high after 16 clean", int'(lock_n), 1);

        // slip during acquisition restarts count (R8)
        rst_n = 1'b0;
        hold_ref(1'b1, 3);
        rst_n = 1'b1;
        periods(8, 10);
        mark();
        skip_edge();
        periods(8, 10);
        check("R8 acquire slip seen", n_raw - r0, 1);
        check("R8 acquire restarted", int'(lock_n), 0);
        periods(8, 8);
        check("R8 locked after restart", int'(lock_n), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule